// File: doc/BRIEF.md
# Privilege-Configurable Masked Status and Interrupt Register File

This block holds the status, interrupt-enable, interrupt-pending and floating-point control registers of a small core. A static configuration input selects the privilege levels the core has: machine only, machine plus user, machine plus user with user-level interrupts, machine plus supervisor plus user, or all of these with user-level interrupts. Each register's writable bit mask is derived from that configuration. Every write is a masked merge, so bits outside the mask keep their stored value.

The supervisor and user status and interrupt registers hold no storage of their own. They are windows onto the machine registers, each seen through a narrower mask. When a level is absent, its window has a zero mask: it reads as zero and writes through it change nothing. The floating-point flags and rounding-mode addresses are windows onto one combined 8-bit register in the same way.

Access is through one single-cycle port. Read data and the illegal flag are combinational on the current state. A write takes effect at the next rising clock edge. The configuration is meant to be held steady and changed only while reset is asserted.

Top module: `csrm_file`

## Requirements
- R1: A write through any address stores `(old & ~mask) | (new & mask)` into the backing register, so bits outside that address's mask keep their value. Cycles with no write leave every register unchanged.
- R2: The configuration codes are 0 machine only, 1 machine+user, 2 machine+user+user interrupts, 3 machine+supervisor+user, and 4 all levels; codes 5 to 7 act as code 0. At 0x304 (enable) and 0x344 (pending), bits 11, 7 and 3 are always writable. Bits 8, 4 and 0 are added in codes 2 and 4. Bits 9, 5 and 1 are added in codes 3 and 4. The registers are 12 bits wide and zero-extended on read.
- R3: The supervisor enable (0x104) and pending (0x144) windows have a zero mask in codes 0, 1 and 2. They expose bits 9, 5 and 1 in code 3, and additionally bits 8, 4 and 0 in code 4.
- R4: The user enable (0x004) and pending (0x044) windows have a zero mask unless the code is 2 or 4. In those codes they expose bits 8, 4 and 0.
- R5: The machine status register is at 0x300. In every configuration these fields are writable there: bit 31, bits 16:15, bits 14:13, bits 10:9, bit 7 and bit 3.
- R6: In machine status, bits 12:11, bit 17 and bit 21 are writable only in codes 1 to 4.
- R7: In machine status, bits 22, 20, 19, 18, 8, 5 and 1 are writable only in codes 3 and 4. Bits 4 and 0 are writable only in codes 2 and 4.
- R8: The supervisor status window is at 0x100. Its mask is zero unless the code is 3 or 4. In those codes it exposes bits 31, 19, 18, 16:15, 14:13, 10:9, 8, 5 and 1, plus bits 4 and 0 in code 4.
- R9: The user status window is at 0x000. Its mask is zero unless the code is 2 or 4. In those codes it exposes bits 31, 16:15, 14:13, 10:9, 4 and 0, plus bits 19 and 18 in code 4.
- R10: A read through a window returns the backing register ANDed with that window's mask. A write through a window changes only the window's masked bits of the shared backing register.
- R11: The combined floating-point register at 0x003 is 8 bits: flags in bits 4:0 and rounding mode in bits 7:5. Address 0x001 reads and writes the 5 flag bits. Address 0x002 reads and writes the 3 rounding-mode bits, right-aligned.
- R12: At 32-bit width, the upper machine status register is at 0x310. Its bit 5 is always writable, and its bit 4 is writable only in codes 3 and 4.
- R13: An access (enable high) to any address not listed above raises the illegal flag in the same cycle, returns zero read data, and changes no register.
- R14: Reset clears every register to zero. Read data in a cycle reflects the state before that cycle's write, and the write is visible on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_cfg | input | 3 | Static privilege-level configuration code |
| csr_en | input | 1 | Access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, masked view of current state |
| csr_illegal | output | 1 | Access targets an unimplemented address |

## Verification
Two things can happen in the same cycle: a read returns a register while a write to that same address, or to another window of the same backing register, is being merged. The random stream issues every access as a read-modify-write, so each operation's read data is compared against the model state from before the edge. The next access, often through a different window, then shows the merged result. All five configurations are run, so the same all-ones and all-zeros patterns reveal which window bits reach the shared register and which are kept.

// File: rtl/csrm_pkg.sv
package csrm_pkg;

    localparam int IRQ_W    = 12;
    localparam int FLAGS_W  = 5;
    localparam int RMODE_W  = 3;
    localparam int FPCTL_W  = FLAGS_W + RMODE_W;

    localparam logic [11:0] A_USTAT  = 12'h000;
    localparam logic [11:0] A_FLAGS  = 12'h001;
    localparam logic [11:0] A_RMODE  = 12'h002;
    localparam logic [11:0] A_FPCTL  = 12'h003;
    localparam logic [11:0] A_UIEN   = 12'h004;
    localparam logic [11:0] A_UIPD   = 12'h044;
    localparam logic [11:0] A_SSTAT  = 12'h100;
    localparam logic [11:0] A_SIEN   = 12'h104;
    localparam logic [11:0] A_SIPD   = 12'h144;
    localparam logic [11:0] A_MSTAT  = 12'h300;
    localparam logic [11:0] A_MIEN   = 12'h304;
    localparam logic [11:0] A_MSTATH = 12'h310;
    localparam logic [11:0] A_MIPD   = 12'h344;

    typedef enum logic [3:0] {
        T_NONE, T_USTAT, T_FLAGS, T_RMODE, T_FPCTL, T_UIEN, T_UIPD,
        T_SSTAT, T_SIEN, T_SIPD, T_MSTAT, T_MSTATH, T_MIEN, T_MIPD
    } csr_tgt_e;

    typedef struct packed {
        logic has_u;
        logic has_s;
        logic has_n;
    } lvl_t;

    function automatic lvl_t decode_cfg(input logic [2:0] code);
        lvl_t l;
        l = '0;
        unique case (code)
            3'd1: l.has_u = 1'b1;
            3'd2: begin l.has_u = 1'b1; l.has_n = 1'b1; end
            3'd3: begin l.has_u = 1'b1; l.has_s = 1'b1; end
            3'd4: begin l.has_u = 1'b1; l.has_s = 1'b1; l.has_n = 1'b1; end
            default: l = '0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/csrm_decode.sv
module csrm_decode
    import csrm_pkg::*;
#(
    parameter bit HAS_STATH = 1'b1
) (
    input  logic [11:0] addr,
    output csr_tgt_e    tgt
);
    always_comb begin
        unique case (addr)
            A_USTAT:  tgt = T_USTAT;
            A_FLAGS:  tgt = T_FLAGS;
            A_RMODE:  tgt = T_RMODE;
            A_FPCTL:  tgt = T_FPCTL;
            A_UIEN:   tgt = T_UIEN;
            A_UIPD:   tgt = T_UIPD;
            A_SSTAT:  tgt = T_SSTAT;
            A_SIEN:   tgt = T_SIEN;
            A_SIPD:   tgt = T_SIPD;
            A_MSTAT:  tgt = T_MSTAT;
            A_MIEN:   tgt = T_MIEN;
            A_MIPD:   tgt = T_MIPD;
            A_MSTATH: tgt = HAS_STATH ? T_MSTATH : T_NONE;
            default:  tgt = T_NONE;
        endcase
    end
endmodule

// File: rtl/csrm_mask_gen.sv
module csrm_mask_gen
    import csrm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]       priv_cfg,
    output logic [XLEN-1:0]  msk_mstat,
    output logic [XLEN-1:0]  msk_sstat,
    output logic [XLEN-1:0]  msk_ustat,
    output logic [IRQ_W-1:0] msk_mi,
    output logic [IRQ_W-1:0] msk_si,
    output logic [IRQ_W-1:0] msk_ui,
    output logic [1:0]       msk_stath
);
    lvl_t            lvl;
    logic [XLEN-1:0] base_m, base_s, base_u, hi_m, hi_s;

    assign lvl = decode_cfg(priv_cfg);

    always_comb begin
        // always-writable machine status fields
        base_m = '0;
        base_m[XLEN-1] = 1'b1;
        base_m[16:15]  = 2'b11;
        base_m[14:13]  = 2'b11;
        base_m[10:9]   = 2'b11;
        base_m[7]      = 1'b1;
        base_m[3]      = 1'b1;
        if (lvl.has_u) begin
            base_m[12:11] = 2'b11;
            base_m[17]    = 1'b1;
            base_m[21]    = 1'b1;
        end
        if (lvl.has_s) begin
            base_m[22] = 1'b1;
            base_m[20] = 1'b1;
            base_m[19] = 1'b1;
            base_m[18] = 1'b1;
            base_m[8]  = 1'b1;
            base_m[5]  = 1'b1;
            base_m[1]  = 1'b1;
        end
        if (lvl.has_n) begin
            base_m[4] = 1'b1;
            base_m[0] = 1'b1;
        end

        base_s = '0;
        if (lvl.has_s) begin
            base_s[XLEN-1] = 1'b1;
            base_s[19:18]  = 2'b11;
            base_s[16:13]  = 4'hF;
            base_s[10:8]   = 3'b111;
            base_s[5]      = 1'b1;
            base_s[1]      = 1'b1;
            if (lvl.has_n) begin
                base_s[4] = 1'b1;
                base_s[0] = 1'b1;
            end
        end

        base_u = '0;
        if (lvl.has_n) begin
            base_u[XLEN-1] = 1'b1;
            base_u[16:13]  = 4'hF;
            base_u[10:9]   = 2'b11;
            base_u[4]      = 1'b1;
            base_u[0]      = 1'b1;
            if (lvl.has_s) base_u[19:18] = 2'b11;
        end

        msk_mi = 12'h888;
        if (lvl.has_n) msk_mi = msk_mi | 12'h111;
        if (lvl.has_s) msk_mi = msk_mi | 12'h222;
        msk_si = '0;
        if (lvl.has_s) msk_si = lvl.has_n ? 12'h333 : 12'h222;
        msk_ui = lvl.has_n ? 12'h111 : 12'h000;
        msk_stath = {1'b1, lvl.has_s};
    end

    generate
        if (XLEN == 64) begin : g_wide
            // upper-word fields: MBE, SBE, SXL, UXL
            assign hi_m = {{(XLEN-38){1'b0}}, 1'b1, lvl.has_s,
                           {2{lvl.has_s}}, {2{lvl.has_u}}, 32'h0};
            assign hi_s = {{(XLEN-34){1'b0}}, {2{lvl.has_s}}, 32'h0};
        end else begin : g_narrow
            assign hi_m = '0;
            assign hi_s = '0;
        end
    endgenerate

    assign msk_mstat = base_m | hi_m;
    assign msk_sstat = base_s | hi_s;
    assign msk_ustat = base_u;
endmodule

// File: rtl/csrm_field_reg.sv
module csrm_field_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= (q & ~mask) | (wdata & mask);
    end

    // R1
    merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q ^ $past(q)) & ~$past(mask)) == '0);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/csrm_file.sv
module csrm_file
    import csrm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      priv_cfg,
    input  logic            csr_en,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal
);
    localparam bit HAS_STATH = (XLEN == 32);
    localparam int PADI = XLEN - IRQ_W;
    localparam int PADF = XLEN - FPCTL_W;

    csr_tgt_e         tgt;
    logic [XLEN-1:0]  msk_mstat, msk_sstat, msk_ustat;
    logic [IRQ_W-1:0] msk_mi, msk_si, msk_ui;
    logic [1:0]       msk_stath;

    logic [XLEN-1:0]    st_q, st_mask;
    logic [IRQ_W-1:0]   ie_q, ie_mask, ip_q, ip_mask, irq_wd;
    logic [FPCTL_W-1:0] fp_q, fp_mask, fp_wd;
    logic [1:0]         sh_q, sh_mask;
    logic               st_we, ie_we, ip_we, fp_we, sh_we, wr;

    csrm_decode #(.HAS_STATH(HAS_STATH)) u_dec (
        .addr (csr_addr),
        .tgt  (tgt)
    );

    csrm_mask_gen #(.XLEN(XLEN)) u_mask (
        .priv_cfg  (priv_cfg),
        .msk_mstat (msk_mstat),
        .msk_sstat (msk_sstat),
        .msk_ustat (msk_ustat),
        .msk_mi    (msk_mi),
        .msk_si    (msk_si),
        .msk_ui    (msk_ui),
        .msk_stath (msk_stath)
    );

    assign csr_illegal = csr_en && (tgt == T_NONE);
    assign wr          = csr_en && csr_we && (tgt != T_NONE);
    assign irq_wd      = csr_wdata[IRQ_W-1:0];

    // write steering: each address picks a backing register and a mask
    always_comb begin
        st_we = 1'b0; st_mask = '0;
        ie_we = 1'b0; ie_mask = '0;
        ip_we = 1'b0; ip_mask = '0;
        fp_we = 1'b0; fp_mask = '0; fp_wd = '0;
        sh_we = 1'b0; sh_mask = '0;
        unique case (tgt)
            T_MSTAT:  begin st_we = wr; st_mask = msk_mstat; end
            T_SSTAT:  begin st_we = wr; st_mask = msk_sstat; end
            T_USTAT:  begin st_we = wr; st_mask = msk_ustat; end
            T_MIEN:   begin ie_we = wr; ie_mask = msk_mi; end
            T_SIEN:   begin ie_we = wr; ie_mask = msk_si; end
            T_UIEN:   begin ie_we = wr; ie_mask = msk_ui; end
            T_MIPD:   begin ip_we = wr; ip_mask = msk_mi; end
            T_SIPD:   begin ip_we = wr; ip_mask = msk_si; end
            T_UIPD:   begin ip_we = wr; ip_mask = msk_ui; end
            T_FLAGS:  begin
                fp_we = wr; fp_mask = 8'h1F;
                fp_wd = {{RMODE_W{1'b0}}, csr_wdata[FLAGS_W-1:0]};
            end
            T_RMODE:  begin
                fp_we = wr; fp_mask = 8'hE0;
                fp_wd = {csr_wdata[RMODE_W-1:0], {FLAGS_W{1'b0}}};
            end
            T_FPCTL:  begin
                fp_we = wr; fp_mask = 8'hFF;
                fp_wd = csr_wdata[FPCTL_W-1:0];
            end
            T_MSTATH: begin sh_we = wr; sh_mask = msk_stath; end
            default:  ;
        endcase
    end

    csrm_field_reg #(.W(XLEN)) u_st (
        .clk(clk), .rst_n(rst_n), .we(st_we), .mask(st_mask),
        .wdata(csr_wdata), .q(st_q));
    csrm_field_reg #(.W(IRQ_W)) u_ie (
        .clk(clk), .rst_n(rst_n), .we(ie_we), .mask(ie_mask),
        .wdata(irq_wd), .q(ie_q));
    csrm_field_reg #(.W(IRQ_W)) u_ip (
        .clk(clk), .rst_n(rst_n), .we(ip_we), .mask(ip_mask),
        .wdata(irq_wd), .q(ip_q));
    csrm_field_reg #(.W(FPCTL_W)) u_fp (
        .clk(clk), .rst_n(rst_n), .we(fp_we), .mask(fp_mask),
        .wdata(fp_wd), .q(fp_q));

    generate
        if (HAS_STATH) begin : g_stath
            csrm_field_reg #(.W(2)) u_sh (
                .clk(clk), .rst_n(rst_n), .we(sh_we), .mask(sh_mask),
                .wdata(csr_wdata[5:4]), .q(sh_q));
        end else begin : g_no_stath
            assign sh_q = 2'b00;
        end
    endgenerate

    // read path: window views are the backing register through their mask
    always_comb begin
        csr_rdata = '0;
        if (csr_en) begin
            unique case (tgt)
                T_MSTAT:  csr_rdata = st_q;
                T_SSTAT:  csr_rdata = st_q & msk_sstat;
                T_USTAT:  csr_rdata = st_q & msk_ustat;
                T_MIEN:   csr_rdata = {{PADI{1'b0}}, ie_q};
                T_SIEN:   csr_rdata = {{PADI{1'b0}}, ie_q & msk_si};
                T_UIEN:   csr_rdata = {{PADI{1'b0}}, ie_q & msk_ui};
                T_MIPD:   csr_rdata = {{PADI{1'b0}}, ip_q};
                T_SIPD:   csr_rdata = {{PADI{1'b0}}, ip_q & msk_si};
                T_UIPD:   csr_rdata = {{PADI{1'b0}}, ip_q & msk_ui};
                T_FLAGS:  csr_rdata = {{(XLEN-FLAGS_W){1'b0}}, fp_q[FLAGS_W-1:0]};
                T_RMODE:  csr_rdata = {{(XLEN-RMODE_W){1'b0}}, fp_q[FPCTL_W-1:FLAGS_W]};
                T_FPCTL:  csr_rdata = {{PADF{1'b0}}, fp_q};
                T_MSTATH: csr_rdata = {{(XLEN-6){1'b0}}, sh_q, 4'b0000};
                default:  csr_rdata = '0;
            endcase
        end
    end

    // R13
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |=> $stable(st_q) && $stable(ie_q) && $stable(ip_q)
                        && $stable(fp_q) && $stable(sh_q));
    // R2
    mie_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ie_q & ~msk_mi) == '0) && ((ip_q & ~msk_mi) == '0));
    // R10
    sie_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_we && csr_addr == A_SIEN)
            |=> ((ie_q ^ $past(ie_q)) & ~$past(msk_si)) == '0);
    // R11
    rmode_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_we && csr_addr == A_RMODE)
            |=> $stable(fp_q[FLAGS_W-1:0]));
endmodule

// File: tb/test_csrm_file.sv
`timescale 1ns/1ps
module test_csrm_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  priv_cfg = 3'd0;
    logic        csr_en = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] m_st;
    logic [11:0] m_ie, m_ip;
    logic [7:0]  m_fp;
    logic [1:0]  m_sh;

    always #2.5 clk = ~clk;

    csrm_file #(.XLEN(32)) i_csrm_file (
        .clk(clk), .rst_n(rst_n), .priv_cfg(priv_cfg), .csr_en(csr_en),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_illegal(csr_illegal));

    localparam logic [11:0] ADDRS [13] = '{12'h000, 12'h001, 12'h002, 12'h003,
        12'h004, 12'h044, 12'h100, 12'h104, 12'h144, 12'h300, 12'h304,
        12'h310, 12'h344};

    function automatic bit hu(input logic [2:0] c); return c >= 3'd1 && c <= 3'd4; endfunction
    function automatic bit hs(input logic [2:0] c); return c == 3'd3 || c == 3'd4; endfunction
    function automatic bit hn(input logic [2:0] c); return c == 3'd2 || c == 3'd4; endfunction

    function automatic logic [31:0] mask_m(input logic [2:0] c);
        logic [31:0] m = 32'h8001_E688;
        if (hu(c)) m |= 32'h0022_1800;
        if (hs(c)) m |= 32'h005C_0122;
        if (hn(c)) m |= 32'h0000_0011;
        return m;
    endfunction
    function automatic logic [31:0] mask_s(input logic [2:0] c);
        logic [31:0] m = 32'h0;
        if (hs(c)) m = 32'h800D_E722 | (hn(c) ? 32'h11 : 32'h0);
        return m;
    endfunction
    function automatic logic [31:0] mask_u(input logic [2:0] c);
        logic [31:0] m = 32'h0;
        if (hn(c)) m = 32'h8001_E611 | (hs(c) ? 32'h000C_0000 : 32'h0);
        return m;
    endfunction
    function automatic logic [11:0] irq_m(input logic [2:0] c);
        return 12'h888 | (hn(c) ? 12'h111 : 12'h0) | (hs(c) ? 12'h222 : 12'h0);
    endfunction
    function automatic logic [11:0] irq_s(input logic [2:0] c);
        return hs(c) ? (12'h222 | (hn(c) ? 12'h111 : 12'h0)) : 12'h0;
    endfunction
    function automatic logic [11:0] irq_u(input logic [2:0] c);
        return hn(c) ? 12'h111 : 12'h0;
    endfunction

    function automatic string req_of(input logic [11:0] a);
        case (a)
            12'h300: return "R5/R6/R7";
            12'h100: return "R8";
            12'h000: return "R9";
            12'h304, 12'h344: return "R2";
            12'h104, 12'h144: return "R3";
            12'h004, 12'h044: return "R4";
            12'h001, 12'h002, 12'h003: return "R11";
            12'h310: return "R12";
            default: return "R13";
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h300: return m_st;
            12'h100: return m_st & mask_s(priv_cfg);
            12'h000: return m_st & mask_u(priv_cfg);
            12'h304: return {20'h0, m_ie};
            12'h104: return {20'h0, m_ie & irq_s(priv_cfg)};
            12'h004: return {20'h0, m_ie & irq_u(priv_cfg)};
            12'h344: return {20'h0, m_ip};
            12'h144: return {20'h0, m_ip & irq_s(priv_cfg)};
            12'h044: return {20'h0, m_ip & irq_u(priv_cfg)};
            12'h001: return {27'h0, m_fp[4:0]};
            12'h002: return {29'h0, m_fp[7:5]};
            12'h003: return {24'h0, m_fp};
            12'h310: return {26'h0, m_sh, 4'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit is_legal(input logic [11:0] a);
        foreach (ADDRS[i]) if (ADDRS[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] mk;
        logic [11:0] ik;
        case (a)
            12'h300, 12'h100, 12'h000: begin
                mk = (a == 12'h300) ? mask_m(priv_cfg) :
                     (a == 12'h100) ? mask_s(priv_cfg) : mask_u(priv_cfg);
                m_st = (m_st & ~mk) | (d & mk);
            end
            12'h304, 12'h104, 12'h004: begin
                ik = (a == 12'h304) ? irq_m(priv_cfg) :
                     (a == 12'h104) ? irq_s(priv_cfg) : irq_u(priv_cfg);
                m_ie = (m_ie & ~ik) | (d[11:0] & ik);
            end
            12'h344, 12'h144, 12'h044: begin
                ik = (a == 12'h344) ? irq_m(priv_cfg) :
                     (a == 12'h144) ? irq_s(priv_cfg) : irq_u(priv_cfg);
                m_ip = (m_ip & ~ik) | (d[11:0] & ik);
            end
            12'h001: m_fp[4:0] = d[4:0];
            12'h002: m_fp[7:5] = d[2:0];
            12'h003: m_fp = d[7:0];
            12'h310: begin
                m_sh[1] = d[5];
                if (hs(priv_cfg)) m_sh[0] = d[4];
            end
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: drive at negedge, sample before the edge, commit to model at the edge
    task automatic op(input bit we, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_en = 1'b1; csr_we = we; csr_addr = a; csr_wdata = d;
        #1;
        chk({req_of(a), "/R14 rdata"}, csr_rdata, is_legal(a) ? exp_read(a) : 32'h0);
        chk({req_of(a), " illegal"}, {31'h0, csr_illegal}, {31'h0, !is_legal(a)});
        @(posedge clk);
        if (we && is_legal(a)) model_write(a, d);
    endtask

    task automatic do_reset(input logic [2:0] c);
        @(negedge clk);
        csr_en = 1'b0; rst_n = 1'b0; priv_cfg = c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_st = '0; m_ie = '0; m_ip = '0; m_fp = '0; m_sh = '0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20231030));
        for (int c = 0; c < 6; c++) begin
            do_reset(c[2:0]);
            // R14: reset state reads as zero everywhere
            foreach (ADDRS[i]) op(1'b0, ADDRS[i], 32'h0);
            // R5 R6 R7: all-ones machine status shows the writable mask
            op(1'b1, 12'h300, 32'hFFFF_FFFF);
            @(negedge clk); csr_en = 1'b1; csr_we = 1'b0; csr_addr = 12'h300; #1;
            chk("R6/R7 mstatus mask", csr_rdata, mask_m(c[2:0]));
            // R10: clearing through the supervisor window keeps other bits
            op(1'b1, 12'h100, 32'h0);
            op(1'b0, 12'h300, 32'h0);
            // R3 R4 R2: all-ones pending, read each window
            op(1'b1, 12'h344, 32'hFFFF_FFFF);
            op(1'b0, 12'h144, 32'h0);
            op(1'b0, 12'h044, 32'h0);
            op(1'b1, 12'h004, 32'hFFFF_FFFF);
            op(1'b0, 12'h304, 32'h0);
            // R11: rounding mode write keeps flags
            op(1'b1, 12'h003, 32'h0000_001F);
            op(1'b1, 12'h002, 32'hFFFF_FFFD);
            op(1'b0, 12'h003, 32'h0);
            // R12
            op(1'b1, 12'h310, 32'hFFFF_FFFF);
            op(1'b0, 12'h310, 32'h0);
            // R13: unimplemented addresses change nothing
            op(1'b1, 12'h305, 32'hFFFF_FFFF);
            op(1'b1, 12'h7C0, 32'hFFFF_FFFF);
            // R1 R10 R14: random read-modify-write stream
            for (int n = 0; n < 400; n++) begin
                logic [11:0] a;
                logic [31:0] d;
                a = ($urandom % 10 == 0) ? 12'($urandom) : ADDRS[$urandom % 13];
                d = $urandom;
                op($urandom % 3 != 0, a, d);
            end
            foreach (ADDRS[i]) op(1'b0, ADDRS[i], 32'h0);
        end
        @(negedge clk); csr_en = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule